// File: doc/BRIEF.md
# Cluster-Format Event Encoder

This block turns one event's worth of channel data into a compact word stream. Upstream logic supplies 1024 signed channel values, each already pedestal-subtracted and held in fixed point with three fractional bits, together with a per-channel keep flag from a threshold stage. The encoder groups every contiguous run of kept channels into a cluster record and emits a variable-length event. Each record holds a length word, a start-index word and the channel values of the run.

Each event is opened by a one-cycle start pulse that carries the event number and the event's options. Channel words then arrive on a valid/ready stream, and common-noise words follow them when the trailer option is set. The block has three modes. Reduced mode packs clusters only. Mixed mode first forwards a complete raw pass of the channels and then reduces a second pass. Window mode ignores the keep flags and emits a single record over a configured range. A one-cycle done pulse marks the end of each output event.

Top module: `cluster_event_encoder`

## Requirements
- R1: After reset, and whenever no event is open, `out_valid`, `in_ready` and `ev_done` are low.
- R2: The first output word of every event is the event number latched at the start pulse.
- R3: In reduced mode (`ev_mode` = 0), each maximal run of kept channels produces one record, and records appear in ascending channel order. A record is three or more words: first the run length minus one, then the index of the run's first channel, then the run's channel values, unchanged and in ascending order. Values of channels that are not kept never appear.
- R4: A run never crosses between index 639 and index 640. Indices 0 to 639 form one detector side and 640 to 1023 the other, so a run that spans both sides is closed at 639 and a new record starts at 640.
- R5: A record covers at most 64 channels. A longer run is emitted as consecutive records, each starting at the channel after the previous record ends.
- R6: When `ev_debug` is set, the 16 common-noise words that follow the channel words on the input stream are appended, unchanged and in order, after the last record.
- R7: In mixed mode (`ev_mode` = 1), the event number is followed by all 1024 words of a first channel pass, unchanged. The records of a second channel pass come next, and then the trailer if it is enabled.
- R8: In window mode (`ev_mode` = 2), the keep flags are ignored. Exactly one record is emitted, with start index `win_start` and length `win_len`. The window is given within one side, with a length from 1 to 64.
- R9: An event with no kept channels outputs only the event-number word, followed by the trailer if `ev_debug` is set.
- R10: `ev_done` is high for exactly one cycle, after the last word of the event. The input stream is accepted only while an event is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | One-cycle pulse that opens an event; honoured only when idle |
| ev_num | input | 16 | Event number, latched at `ev_start` |
| ev_mode | input | 2 | 0 reduced, 1 mixed, 2 window, 3 treated as reduced |
| ev_debug | input | 1 | Append the common-noise trailer |
| win_start | input | 10 | First channel of the window (window mode) |
| win_len | input | 7 | Window length, 1 to 64 (window mode) |
| ch_valid | input | 1 | Channel or noise word present |
| ch_data | input | 16 | Signed channel or noise value, scaled by 8 |
| ch_sel | input | 1 | Keep flag for the current channel |
| in_ready | output | 1 | Block accepts `ch_data` this cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output word |
| ev_done | output | 1 | End-of-event pulse |

## Verification
Faults in run tracking show up within the same event as a wrong length or start word in the first record that follows the fault. Typical causes are a missed side or length split, or a stale start index. A read pointer that is off by one corrupts value words within one record. A mode or trailer sequencing error shows as extra or missing words, which the scoreboard detects at the done pulse of that event. The cases that exercise these faults are runs that straddle index 639/640, runs longer than 64, a run that ends at the last channel, window mode with conflicting keep flags, and empty events with and without the trailer.

// File: rtl/ce_pkg.sv
// Shared types for the cluster event encoder.
// Assumes: mode codes are fixed by the external configuration interface.
package ce_pkg;
    localparam logic [1:0] MODE_REDUCED = 2'd0;
    localparam logic [1:0] MODE_MIXED   = 2'd1;
    localparam logic [1:0] MODE_WINDOW  = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EVNUM,
        ST_RAW,
        ST_SCAN,
        ST_HLEN,
        ST_HIDX,
        ST_BODY,
        ST_TRAIL,
        ST_DONE
    } ce_state_t;
endpackage

// File: rtl/ce_run_buf.sv
// Run value buffer: holds the values of the cluster being collected
// until its header words have been emitted.
// Assumes: one write port and one asynchronous read port; a write and a
// read never target the same entry in the same cycle.
module ce_run_buf #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    // Store one channel value of the open run.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ce_win_sel.sv
// Keep-flag qualifier: passes the upstream flag through, or, in window
// mode, replaces it with membership of the configured index window.
// Assumes: window start plus length fits within IDXW+1 bits.
module ce_win_sel #(
    parameter int IDXW = 10,
    parameter int LENW = 7,
    localparam int EW  = IDXW + 1
) (
    input  logic            win_mode,
    input  logic [IDXW-1:0] win_start,
    input  logic [LENW-1:0] win_len,
    input  logic [IDXW-1:0] idx,
    input  logic            flag,
    output logic            keep
);
    logic [EW-1:0] lo, hi, cur;

    // Decide whether the current channel belongs to a cluster.
    always_comb begin
        lo   = EW'(win_start);
        hi   = EW'(win_start) + EW'(win_len);
        cur  = EW'(idx);
        keep = win_mode ? ((cur >= lo) && (cur < hi)) : flag;
    end
endmodule

// File: rtl/cluster_event_encoder.sv
// Cluster event encoder top: sequences event number, optional raw pass,
// cluster records (length-1, first index, values) and optional noise trailer.
// Assumes: upstream keeps ch_valid/ch_data stable until in_ready; ev_start
// arrives only while idle; window length is 1..MAXLEN within one side.
module cluster_event_encoder #(
    parameter int W      = 16,
    parameter int NCHAN  = 1024,
    parameter int SPLIT  = 640,
    parameter int MAXLEN = 64,
    parameter int NNOISE = 16,
    localparam int IDXW  = $clog2(NCHAN),
    localparam int LENW  = $clog2(MAXLEN + 1),
    localparam int AW    = $clog2(MAXLEN),
    localparam int NSW   = $clog2(NNOISE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_start,
    input  logic [W-1:0]    ev_num,
    input  logic [1:0]      ev_mode,
    input  logic            ev_debug,
    input  logic [IDXW-1:0] win_start,
    input  logic [LENW-1:0] win_len,
    input  logic            ch_valid,
    input  logic [W-1:0]    ch_data,
    input  logic            ch_sel,
    output logic            in_ready,
    output logic            out_valid,
    output logic [W-1:0]    out_data,
    output logic            ev_done
);
    import ce_pkg::*;

    ce_state_t       state;
    logic [W-1:0]    num_q;
    logic [1:0]      mode_q;
    logic            dbg_q;
    logic [IDXW-1:0] wstart_q;
    logic [LENW-1:0] wlen_q;
    logic [IDXW-1:0] idx;
    logic [LENW-1:0] run_len;
    logic [IDXW-1:0] run_first;
    logic [LENW-1:0] rd_ptr;
    logic [NSW-1:0]  ncnt;
    logic            chans_done;
    logic            keep;
    logic [W-1:0]    buf_rd;
    logic            buf_we;
    logic [LENW-1:0] len_next;
    logic            last_idx, side_end, accept;

    ce_win_sel #(.IDXW(IDXW), .LENW(LENW)) u_sel (
        .win_mode  (mode_q == MODE_WINDOW),
        .win_start (wstart_q),
        .win_len   (wlen_q),
        .idx       (idx),
        .flag      (ch_sel),
        .keep      (keep)
    );

    ce_run_buf #(.W(W), .DEPTH(MAXLEN)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_addr (run_len[AW-1:0]),
        .wr_data (ch_data),
        .rd_addr (rd_ptr[AW-1:0]),
        .rd_data (buf_rd)
    );

    // Stream acceptance and run-growth terms for the current cycle.
    always_comb begin
        in_ready = (state == ST_RAW) || (state == ST_SCAN) || (state == ST_TRAIL);
        accept   = in_ready && ch_valid;
        last_idx = (idx == IDXW'(NCHAN - 1));
        side_end = (idx == IDXW'(SPLIT - 1));
        buf_we   = accept && (state == ST_SCAN) && keep;
        len_next = run_len + LENW'(1);
    end

    // Event sequencer: mode order, run closing and word emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            num_q      <= '0;
            mode_q     <= MODE_REDUCED;
            dbg_q      <= 1'b0;
            wstart_q   <= '0;
            wlen_q     <= '0;
            idx        <= '0;
            run_len    <= '0;
            run_first  <= '0;
            rd_ptr     <= '0;
            ncnt       <= '0;
            chans_done <= 1'b0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            ev_done    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            ev_done   <= 1'b0;
            unique case (state)
                ST_IDLE: if (ev_start) begin
                    num_q      <= ev_num;
                    mode_q     <= ev_mode;
                    dbg_q      <= ev_debug;
                    wstart_q   <= win_start;
                    wlen_q     <= win_len;
                    idx        <= '0;
                    run_len    <= '0;
                    rd_ptr     <= '0;
                    ncnt       <= '0;
                    chans_done <= 1'b0;
                    state      <= ST_EVNUM;
                end
                ST_EVNUM: begin
                    out_valid <= 1'b1;
                    out_data  <= num_q;
                    state     <= (mode_q == MODE_MIXED) ? ST_RAW : ST_SCAN;
                end
                ST_RAW: if (accept) begin
                    out_valid <= 1'b1;
                    out_data  <= ch_data;
                    idx       <= last_idx ? '0 : idx + IDXW'(1);
                    if (last_idx) state <= ST_SCAN;
                end
                ST_SCAN: if (accept) begin
                    idx        <= last_idx ? '0 : idx + IDXW'(1);
                    chans_done <= last_idx;
                    if (keep) begin
                        if (run_len == '0) run_first <= idx;
                        run_len <= len_next;
                        if (len_next == LENW'(MAXLEN) || side_end || last_idx)
                            state <= ST_HLEN;
                    end else if (run_len != '0) begin
                        state <= ST_HLEN;
                    end else if (last_idx) begin
                        state <= dbg_q ? ST_TRAIL : ST_DONE;
                    end
                end
                ST_HLEN: begin
                    out_valid <= 1'b1;
                    out_data  <= W'(run_len - LENW'(1));
                    state     <= ST_HIDX;
                end
                ST_HIDX: begin
                    out_valid <= 1'b1;
                    out_data  <= W'(run_first);
                    state     <= ST_BODY;
                end
                ST_BODY: begin
                    out_valid <= 1'b1;
                    out_data  <= buf_rd;
                    rd_ptr    <= rd_ptr + LENW'(1);
                    if (rd_ptr == run_len - LENW'(1)) begin
                        rd_ptr  <= '0;
                        run_len <= '0;
                        if (!chans_done)  state <= ST_SCAN;
                        else if (dbg_q)   state <= ST_TRAIL;
                        else              state <= ST_DONE;
                    end
                end
                ST_TRAIL: if (accept) begin
                    out_valid <= 1'b1;
                    out_data  <= ch_data;
                    ncnt      <= ncnt + NSW'(1);
                    if (ncnt == NSW'(NNOISE - 1)) state <= ST_DONE;
                end
                ST_DONE: begin
                    ev_done <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cluster_event_encoder_chk.sv
// Port-level checker for the cluster event encoder, bound to every instance.
// Assumes: ev_start is pulsed only while the encoder is idle.
module cluster_event_encoder_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ev_start,
    input logic [W-1:0] ev_num,
    input logic         in_ready,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         ev_done
);
    logic         busy;
    logic         first_pend;
    logic [W-1:0] num_seen;

    // Track event open/close and the expected first word from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            first_pend <= 1'b0;
            num_seen   <= '0;
        end else begin
            if (ev_start && !busy) begin
                busy       <= 1'b1;
                first_pend <= 1'b1;
                num_seen   <= ev_num;
            end else begin
                if (ev_done)   busy       <= 1'b0;
                if (out_valid) first_pend <= 1'b0;
            end
        end
    end

    a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !in_ready));

    a_r2_evnum_first: assert property (@(posedge clk) disable iff (!rst_n)
        (first_pend && out_valid) |-> (out_data == num_seen));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> !ev_done);

    a_r10_done_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> (!out_valid && !in_ready && busy));
endmodule

bind cluster_event_encoder cluster_event_encoder_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .ev_num    (ev_num),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .ev_done   (ev_done)
);

// File: tb/cluster_event_encoder_tb_top.sv
// Scoreboard bench: the driver builds expected words from the requirements
// into a queue, and a monitor pops and compares each output word.
module cluster_event_encoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 1024;
    localparam int NNZ = 16;

    typedef struct {
        logic [15:0] d;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 1'b0;
    logic [15:0] ev_num = '0;
    logic [1:0]  ev_mode = '0;
    logic        ev_debug = 1'b0;
    logic [9:0]  win_start = '0;
    logic [6:0]  win_len = '0;
    logic        ch_valid = 1'b0;
    logic [15:0] ch_data = '0;
    logic        ch_sel = 1'b0;
    logic        in_ready, out_valid, ev_done;
    logic [15:0] out_data;

    exp_t        q[$];
    logic        sel_a [NCH];
    logic [15:0] val_a [NCH];
    logic [15:0] nz_a  [NNZ];
    int          total = 0;
    int          bad = 0;
    int          done_seen = 0;
    int          cyc = 0;

    cluster_event_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_num(ev_num),
        .ev_mode(ev_mode), .ev_debug(ev_debug), .win_start(win_start),
        .win_len(win_len), .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_sel(ch_sel), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .ev_done(ev_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] d, input string tag);
        exp_t e;
        e.d = d;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Expected-word model written from the requirements.
    task automatic build_expected(input logic [15:0] evn, input int mode, input bit dbg,
                                  input int ws, input int wl, input string tag);
        logic [15:0] rb [64];
        int rl = 0;
        int rf = 0;
        push(evn, "R2");
        if (mode == 1)
            for (int i = 0; i < NCH; i++) push(val_a[i], "R7");
        for (int i = 0; i < NCH; i++) begin
            bit s;
            bit cl;
            s  = (mode == 2) ? (i >= ws && i < ws + wl) : sel_a[i];
            cl = 1'b0;
            if (s) begin
                if (rl == 0) rf = i;
                rb[rl] = val_a[i];
                rl++;
                cl = (rl == 64) || (i == 639) || (i == NCH - 1);
            end else begin
                cl = (rl > 0);
            end
            if (cl) begin
                push(16'(rl - 1), tag);
                push(16'(rf), tag);
                for (int k = 0; k < rl; k++) push(rb[k], tag);
                rl = 0;
            end
        end
        if (dbg)
            for (int k = 0; k < NNZ; k++) push(nz_a[k], "R6");
    endtask

    task automatic send(input logic [15:0] d, input logic s);
        ch_valid = 1'b1;
        ch_data  = d;
        ch_sel   = s;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        ch_valid = 1'b0;
    endtask

    task automatic run_event(input logic [15:0] evn, input int mode, input bit dbg,
                             input int ws, input int wl, input string tag);
        int d0;
        build_expected(evn, mode, dbg, ws, wl, tag);
        d0 = done_seen;
        @(negedge clk);
        ev_start  = 1'b1;
        ev_num    = evn;
        ev_mode   = 2'(mode);
        ev_debug  = dbg;
        win_start = 10'(ws);
        win_len   = 7'(wl);
        @(negedge clk);
        ev_start = 1'b0;
        if (mode == 1)
            for (int i = 0; i < NCH; i++) send(val_a[i], ~sel_a[i]);
        for (int i = 0; i < NCH; i++) send(val_a[i], sel_a[i]);
        if (dbg)
            for (int k = 0; k < NNZ; k++) send(nz_a[k], 1'b0);
        while (done_seen == d0) @(negedge clk);
        @(negedge clk);
        check(ev_done == 1'b0, "R10 done width", int'(ev_done), 0);
    endtask

    task automatic set_sel(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) sel_a[i] = 1'b1;
    endtask

    task automatic clear_sel();
        for (int i = 0; i < NCH; i++) sel_a[i] = 1'b0;
    endtask

    // Monitor: compare each output word against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R3 unexpected word", int'(out_data), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(out_data == e.d, e.tag, int'(out_data), int'(e.d));
            end
        end
        if (rst_n && ev_done) begin
            check(q.size() == 0, "R10 words missing at done", q.size(), 0);
            q.delete();
            done_seen++;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) val_a[i] = 16'((i * 53) ^ 16'h8421);
        for (int k = 0; k < NNZ; k++) nz_a[k] = 16'hF000 + 16'(k * 7);
        clear_sel();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready  == 1'b0, "R1 in_ready",  int'(in_ready),  0);
        check(ev_done   == 1'b0, "R1 ev_done",   int'(ev_done),   0);

        // R9: empty event, no trailer
        clear_sel();
        run_event(16'h0011, 0, 1'b0, 0, 0, "R9");

        // R3: isolated runs, including a single channel and index 0
        clear_sel();
        set_sel(0, 0); set_sel(5, 7); set_sel(100, 100); set_sel(300, 320);
        run_event(16'h0022, 0, 1'b0, 0, 0, "R3");

        // R4: run straddling the side boundary
        clear_sel();
        set_sel(636, 645);
        run_event(16'h0033, 0, 1'b0, 0, 0, "R4");

        // R5: long run split at 64 channels, plus exactly 64
        clear_sel();
        set_sel(10, 149); set_sel(200, 263);
        run_event(16'h0044, 0, 1'b0, 0, 0, "R5");

        // R6: trailer after a run closed by the last channel
        clear_sel();
        set_sel(50, 52); set_sel(1020, 1023);
        run_event(16'h0055, 0, 1'b1, 0, 0, "R6");

        // R7: mixed mode with trailer
        clear_sel();
        set_sel(700, 710);
        run_event(16'h0066, 1, 1'b1, 0, 0, "R7");

        // R8: window mode ignores conflicting keep flags
        clear_sel();
        set_sel(0, 40); set_sel(715, 760);
        run_event(16'h0077, 2, 1'b0, 700, 20, "R8");

        // R9: empty event with trailer
        clear_sel();
        run_event(16'h0088, 0, 1'b1, 0, 0, "R9");

        // R1: idle again after the last event
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b0, "R1 idle after events",
              int'({out_valid, in_ready}), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule